// File: doc/BRIEF.md
# Video RAM Block-Copy Engine

This engine moves data from anywhere in the 16-bit address space into the video RAM window at 0x8000. Software sets a source and a destination through four byte-wide address registers, then writes a control byte. The control byte sets the length and one of two modes. In immediate mode the whole length is copied at once. In blank-paced mode one 16-byte unit is copied each time the display enters its horizontal-blank state (display mode 0) while the LCD is on.

While bytes are moving, the engine holds the processor with a stall output. Each byte takes two clock cycles: a read request in the first and a write in the second, where the write data is the byte returned by memory. At the end of each run, the advanced source and destination are written back into the address registers. Reading the control register returns the number of units still to go, or 0xFF when the engine is idle.

Top module: `vram_dma`

## Requirements
- R1: A control write takes the source as {reg0, reg1} with bits 3:0 forced to zero.
- R2: A control write takes the destination as 0x8000 | ({reg2, reg3} & 0x1FF0).
- R3: If the computed source lies in 0x8000–0x9FFF, nothing is copied and the control register reads back the written value with bit 7 set.
- R4: A control write with bit 7 clear, while blank-paced mode is not armed, copies (bits 6:0 + 1) × 16 bytes. The stall output is high for exactly two cycles per byte, and afterwards the control register reads 0xFF.
- R5: Each byte is a read-request cycle followed by a write cycle. The write data is the returned read byte. Source and destination each advance by one per byte.
- R6: When armed in blank-paced mode, the engine copies exactly 16 bytes on each entry into the state "LCD on and display mode 0". It does not copy again until that state is left and entered once more.
- R7: In blank-paced mode, a control write leaves bits 6:0 in the control register. That value drops by one after each 16-byte unit. When it reaches 0xFF, the mode disarms and no more units are copied.
- R8: When a run ends, reg0/reg1 hold the next source address and reg2/reg3 hold the next destination address.
- R9: Arming blank-paced mode with the LCD off copies nothing. The control register then reads 0x80 | ((value + 1) & 0x7F).
- R10: Arming blank-paced mode while the LCD is on and the display is already in mode 0 starts the first unit in the next cycle.
- R11: Register select 0..3 addresses the four address registers and 4 addresses control; any other select reads 0xFF. After reset the address registers read 0, control reads 0xFF and the stall is low.
- R12: Register writes made while the stall output is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| lcd_on | input | 1 | LCD enable |
| disp_mode | input | 2 | Current display mode, 0 = horizontal blank |
| mem_rd | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| mem_wr | output | 1 | Memory write strobe |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| cpu_stall | output | 1 | Holds the processor while bytes move |

## Verification
The assertions assume that memory returns read data exactly one cycle after a request, with no wait states. They also assume that the processor, being stalled, does not rely on register writes landing during a run. The bench's memory model always answers in that single fixed cycle, with a byte computed from the address. Display-mode and LCD changes are made only between runs or held stable across a burst, so that each entry into blank is a single clean event.

// File: rtl/vram_dma.sv
`timescale 1ns/1ps
module vram_dma #(
  parameter int UNIT   = 16,
  parameter int MAXLEN = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        lcd_on,
  input  logic [1:0]  disp_mode,
  output logic        mem_rd,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        cpu_stall
);
  localparam int LW = $clog2(MAXLEN * UNIT) + 1;

  logic [7:0]    r_shi, r_slo, r_dhi, r_dlo, ctrl;
  logic          hb_mode, busy, phase, hb_prev;
  logic [15:0]   src, dst;
  logic [LW-1:0] left;

  wire        hb_now  = lcd_on && (disp_mode == 2'd0);
  wire        ctl_wr  = reg_we && !busy && (reg_addr == 3'd4);
  wire [15:0] src_req = {r_shi, r_slo} & 16'hFFF0;
  wire [15:0] dst_req = 16'h8000 | ({r_dhi, r_dlo} & 16'h1FF0);
  wire        src_bad = (src_req[15:13] == 3'b100);
  wire        arm     = reg_wdata[7];
  wire        go_now  = (!hb_mode && !arm) || hb_now;
  wire [15:0] src_nx  = src + 16'd1;
  wire [15:0] dst_nx  = dst + 16'd1;
  wire [7:0]  ctrl_dn = ctrl - 8'd1;

  assign mem_rd      = busy && !phase;
  assign mem_wr      = busy && phase;
  assign mem_rd_addr = src;
  assign mem_wr_addr = dst;
  assign mem_wr_data = mem_rd_data;
  assign cpu_stall   = busy;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = r_shi;
      3'd1:    reg_rdata = r_slo;
      3'd2:    reg_rdata = r_dhi;
      3'd3:    reg_rdata = r_dlo;
      3'd4:    reg_rdata = ctrl;
      default: reg_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_shi <= '0; r_slo <= '0; r_dhi <= '0; r_dlo <= '0;
      ctrl <= 8'hFF; hb_mode <= 1'b0; busy <= 1'b0; phase <= 1'b0;
      hb_prev <= 1'b0; src <= '0; dst <= '0; left <= '0;
    end else begin
      hb_prev <= hb_now;
      if (reg_we && !busy) begin
        case (reg_addr)
          3'd0: r_shi <= reg_wdata;
          3'd1: r_slo <= reg_wdata;
          3'd2: r_dhi <= reg_wdata;
          3'd3: r_dlo <= reg_wdata;
          default: ;
        endcase
      end
      if (busy) begin
        phase <= !phase;
        if (phase) begin
          src  <= src_nx;
          dst  <= dst_nx;
          left <= left - LW'(1);
          if (left == LW'(1)) begin
            busy <= 1'b0;
            {r_shi, r_slo} <= src_nx;
            {r_dhi, r_dlo} <= dst_nx;
            if (hb_mode) begin
              ctrl <= ctrl_dn;
              if (ctrl_dn == 8'hFF) hb_mode <= 1'b0;
            end else begin
              ctrl <= 8'hFF;
            end
          end
        end
      end else if (ctl_wr) begin
        if (src_bad) begin
          ctrl <= reg_wdata | 8'h80;
        end else begin
          hb_mode <= arm;
          src     <= src_req;
          dst     <= dst_req;
          if (go_now) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            left  <= arm ? LW'(UNIT) : LW'((32'(reg_wdata[6:0]) + 32'd1) * UNIT);
            ctrl  <= {1'b0, reg_wdata[6:0]};
          end else if (arm && !lcd_on) begin
            ctrl  <= {1'b1, reg_wdata[6:0] + 7'd1};
          end else begin
            ctrl  <= {1'b0, reg_wdata[6:0]};
          end
        end
      end else if (hb_mode && hb_now && !hb_prev) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        left  <= LW'(UNIT);
      end
    end
  end
endmodule

// File: rtl/vram_dma_chk.sv
`timescale 1ns/1ps
module vram_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic [15:0] mem_rd_addr,
  input logic        mem_wr,
  input logic [15:0] mem_wr_addr,
  input logic        cpu_stall
);
  AST_MOVE_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> cpu_stall); // R4
  AST_RD_THEN_WR:  assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr); // R5
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(mem_rd)); // R5
  AST_SRC_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                     (mem_rd && $past(mem_wr)) |-> mem_rd_addr == $past(mem_rd_addr, 2) + 16'd1); // R5
  AST_DST_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
                     (mem_wr && $past(mem_wr, 2)) |-> mem_wr_addr == $past(mem_wr_addr, 2) + 16'd1); // R5
endmodule

bind vram_dma vram_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_rd_addr(mem_rd_addr),
  .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .cpu_stall(cpu_stall)
);

// File: tb/vram_dma_bench.sv
`timescale 1ns/1ps
module vram_dma_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic lcd_on = 1'b0;
  logic [1:0] disp_mode = 2'd2;
  logic mem_rd, mem_wr, cpu_stall;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0] mem_rd_data = 8'd0;
  logic [7:0] mem_wr_data;

  always #4 clk = ~clk;

  vram_dma u_vram_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcd_on(lcd_on),
    .disp_mode(disp_mode), .mem_rd(mem_rd), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .cpu_stall(cpu_stall)
  );

  function automatic int pat(int a);
    return (a ^ (a >> 8) ^ 'h5A) & 'hFF;
  endfunction

  always @(posedge clk) mem_rd_data <= 8'(pat(int'(mem_rd_addr)));

  int n_cmp = 0, n_bad = 0, stall_cycles = 0;
  string cur_tag = "R11";

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model
  int m_reg[4];
  int m_ctrl, m_src, m_dst, m_ph, t_s, t_d;
  bit m_hb, m_prev, m_busy, m_now, m_was;
  int q_s[$], q_d[$];

  task automatic m_start(int s, int d, int n);
    for (int i = 0; i < n; i++) begin
      q_s.push_back((s + i) & 'hFFFF);
      q_d.push_back((d + i) & 'hFFFF);
    end
    m_src = (s + n) & 'hFFFF;
    m_dst = (d + n) & 'hFFFF;
    m_ph = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
      m_ctrl = 255; m_hb = 0; m_prev = 0; m_ph = 0; m_src = 0; m_dst = 0;
      q_s.delete(); q_d.delete();
    end else begin
      m_now = lcd_on && disp_mode == 2'd0;
      m_busy = q_s.size() > 0;
      if (reg_we && !m_busy && reg_addr < 3'd4) m_reg[reg_addr] = int'(reg_wdata);
      if (m_busy) begin
        if (m_ph == 0) m_ph = 1;
        else begin
          m_ph = 0;
          void'(q_s.pop_front());
          void'(q_d.pop_front());
          if (q_s.size() == 0) begin
            m_reg[0] = m_src >> 8; m_reg[1] = m_src & 255;
            m_reg[2] = m_dst >> 8; m_reg[3] = m_dst & 255;
            if (m_hb) begin
              m_ctrl = (m_ctrl + 255) & 255;
              if (m_ctrl == 255) m_hb = 0;
            end else m_ctrl = 255;
          end
        end
      end else if (reg_we && reg_addr == 3'd4) begin
        t_s = ((m_reg[0] << 8) | m_reg[1]) & 'hFFF0;
        t_d = 'h8000 | (((m_reg[2] << 8) | m_reg[3]) & 'h1FF0);
        if (t_s >= 'h8000 && t_s < 'hA000) m_ctrl = int'(reg_wdata) | 'h80;
        else begin
          m_was = m_hb;
          m_hb = reg_wdata[7];
          m_src = t_s; m_dst = t_d;
          if ((!m_was && !reg_wdata[7]) || m_now) begin
            m_start(t_s, t_d, reg_wdata[7] ? 16 : ((int'(reg_wdata) & 127) + 1) * 16);
            m_ctrl = int'(reg_wdata) & 127;
          end else if (reg_wdata[7] && !lcd_on) m_ctrl = 'h80 | ((int'(reg_wdata) + 1) & 127);
          else m_ctrl = int'(reg_wdata) & 127;
        end
      end else if (m_hb && m_now && !m_prev) m_start(m_src, m_dst, 16);
      m_prev = m_now;
    end
  end

  always @(posedge clk) begin
    #3;
    if (cpu_stall) stall_cycles++;
    check(cur_tag, "stall", int'(cpu_stall), int'(q_s.size() > 0));
    check(cur_tag, "rd", int'(mem_rd), int'(q_s.size() > 0 && m_ph == 0));
    check(cur_tag, "wr", int'(mem_wr), int'(q_s.size() > 0 && m_ph == 1));
    if (q_s.size() > 0 && m_ph == 0) check(cur_tag, "rd_addr", int'(mem_rd_addr), q_s[0]);
    if (q_s.size() > 0 && m_ph == 1) begin
      check(cur_tag, "wr_addr", int'(mem_wr_addr), q_d[0]);
      check(cur_tag, "wr_data", int'(mem_wr_data), pat(q_s[0]));
    end
    check(cur_tag, "rdata", int'(reg_rdata),
          reg_addr < 3'd4 ? m_reg[reg_addr] : (reg_addr == 3'd4 ? m_ctrl : 255));
  end

  task automatic wr_reg(int a, int v);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(v);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic chk_reg(int a, int e, string tag);
    @(negedge clk); reg_addr = 3'(a); #1;
    check(tag, "reg", int'(reg_rdata), e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    cur_tag = "R11";
    chk_reg(0, 0, "R11"); chk_reg(3, 0, "R11");
    chk_reg(4, 'hFF, "R11"); chk_reg(6, 'hFF, "R11");
    check("R11", "stall", int'(cpu_stall), 0);

    cur_tag = "R4";
    wr_reg(0, 'h12); wr_reg(1, 'h3F); wr_reg(2, 'hE5); wr_reg(3, 'h47);
    stall_cycles = 0;
    wr_reg(4, 'h02);
    #1 check("R1", "first rd_addr", int'(mem_rd_addr), 'h1230);
    @(negedge clk); #1;
    check("R2", "first wr_addr", int'(mem_wr_addr), 'h8540);
    check("R5", "first wr_data", int'(mem_wr_data), pat('h1230));
    wr_reg(0, 'hAA);
    wait_cyc(110);
    check("R4", "stall cycles", stall_cycles, 96);
    chk_reg(4, 'hFF, "R4");
    chk_reg(0, 'h12, "R12");
    chk_reg(1, 'h60, "R8"); chk_reg(2, 'h85, "R8"); chk_reg(3, 'h70, "R8");

    cur_tag = "R3";
    wr_reg(0, 'h88); wr_reg(1, 'h00);
    stall_cycles = 0;
    wr_reg(4, 'h05);
    wait_cyc(10);
    chk_reg(4, 'h85, "R3");
    check("R3", "stall cycles", stall_cycles, 0);

    cur_tag = "R9";
    wr_reg(0, 'h40); wr_reg(1, 'h00); wr_reg(2, 'h00); wr_reg(3, 'h00);
    wr_reg(4, 'h83);
    wait_cyc(10);
    chk_reg(4, 'h84, "R9");
    check("R9", "stall cycles", stall_cycles, 0);
    wr_reg(4, 'h00);
    wait_cyc(4);
    check("R9", "stall cycles after cancel", stall_cycles, 0);

    cur_tag = "R6";
    @(negedge clk); lcd_on = 1'b1; disp_mode = 2'd2;
    wr_reg(4, 'h81);
    wait_cyc(5);
    chk_reg(4, 'h01, "R7");
    check("R6", "idle before blank", stall_cycles, 0);
    @(negedge clk); disp_mode = 2'd0;
    wait_cyc(40);
    check("R6", "first burst", stall_cycles, 32);
    chk_reg(4, 'h00, "R7");
    wait_cyc(40);
    check("R6", "one burst per blank", stall_cycles, 32);
    @(negedge clk); disp_mode = 2'd3;
    wait_cyc(5);
    @(negedge clk); disp_mode = 2'd0;
    wait_cyc(40);
    cur_tag = "R7";
    check("R7", "second burst", stall_cycles, 64);
    chk_reg(4, 'hFF, "R7");
    @(negedge clk); disp_mode = 2'd2;
    wait_cyc(5);
    @(negedge clk); disp_mode = 2'd0;
    wait_cyc(40);
    check("R7", "disarmed", stall_cycles, 64);
    chk_reg(0, 'h40, "R8"); chk_reg(1, 'h20, "R8");
    chk_reg(2, 'h80, "R8"); chk_reg(3, 'h20, "R8");

    cur_tag = "R10";
    wr_reg(0, 'h50); wr_reg(1, 'h07); wr_reg(2, 'h01); wr_reg(3, 'h00);
    wr_reg(4, 'h80);
    #1 check("R10", "immediate stall", int'(cpu_stall), 1);
    check("R10", "rd_addr", int'(mem_rd_addr), 'h5000);
    wait_cyc(40);
    chk_reg(4, 'hFF, "R10");
    chk_reg(1, 'h10, "R8"); chk_reg(3, 'h10, "R8");
    check("R10", "stall cycles", stall_cycles, 96);

    wait_cyc(4);
    finish_run();
  end
endmodule